// File: doc/BRIEF.md
# Cyclic Prefix Serializer

This block sits between an 8-point IFFT and a digital up-converter on the transmit side of an OFDM link. It takes one time-domain symbol at a time. The symbol comes as a vector of eight real samples and a vector of eight imaginary samples, each sample 16 bits wide. The block copies the last three words of the symbol in front of it as a guard interval. This forms a 19-word (304-bit) frame, which the block sends out one 16-bit word per clock.

A word counter picks the word that leaves on each cycle. The input uses a valid/ready handshake. The block accepts a new symbol only while it is idle, so a symbol offered during serialization waits until the current frame has fully left. The output is a 16-bit word qualified by a valid flag for the up-converter.

Top module: `cp_serializer`

## Requirements
- R1: Reset is asynchronous and active high. While it is asserted, and in the cycle after it is released, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0. Asserting it mid-frame abandons the frame at once.
- R2: A symbol is captured on a rising clock edge where `in_valid` and `in_ready` are both 1. Its first frame word appears on the output in the cycle that follows that edge.
- R3: The first three output words of a frame are imaginary samples 5, 6 and 7, in that order. Sample k sits at bits [16k+15:16k] of its input vector.
- R4: After the prefix, the frame carries real samples 0 through 7 in order, then imaginary samples 0 through 7 in order.
- R5: `out_valid` stays 1 for exactly 19 consecutive cycles per accepted symbol.
- R6: `in_ready` is 0 while a frame is being sent. `in_valid` and input data presented during that time do not change any word of the frame in flight.
- R7: After the 19th word, the word counter returns to zero. In the next cycle `out_valid` is 0 and `in_ready` is 1. A symbol held valid across the frame is accepted on the next edge.
- R8: `out_data` is 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | A symbol is offered on `in_re`/`in_im` |
| in_ready | output | 1 | Block is idle and will take a symbol |
| in_re | input | 128 | Real samples 0..7, sample k at bits [16k+15:16k] |
| in_im | input | 128 | Imaginary samples 0..7, same layout |
| out_valid | output | 1 | `out_data` carries a frame word |
| out_data | output | 16 | Current frame word, zero when idle |

## Verification
The main function is tried with four sample patterns:
- An ascending ramp in both halves, with a different base for real and imaginary. It catches any misplaced or repeated word position.
- A constant real half against a different constant imaginary half. It separates a real/imaginary swap from an index error.
- Patterns with the sign bit set and with wrapping steps. They expose truncated or shifted sample slices.
- A zero real half against a descending imaginary half. It shows whether prefix words come from the tail of the imaginary vector.

Directed runs then do three things:
- Hold `in_valid` with altered data across a whole frame, to show it is ignored and then taken.
- Reset in mid-frame.
- Compare the idle output against zero.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Maps a frame position to the symbol word it carries.
  // Symbol word order: real 0..N-1, then imaginary 0..N-1.
  function automatic int frame_src(input int pos, input int cp_words, input int sym_words);
    if (pos < cp_words) return sym_words - cp_words + pos;
    return pos - cp_words;
  endfunction

endpackage

// File: rtl/cps_frame_build.sv
module cps_frame_build
  import cps_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int N_PTS    = 8,
  parameter int CP_WORDS = 3,
  localparam int SYM_WORDS   = 2 * N_PTS,
  localparam int FRAME_WORDS = CP_WORDS + SYM_WORDS
) (
  input  logic [N_PTS*SAMPLE_W-1:0]              re_i,
  input  logic [N_PTS*SAMPLE_W-1:0]              im_i,
  output logic [FRAME_WORDS-1:0][SAMPLE_W-1:0]   frame_o
);

  logic [SYM_WORDS-1:0][SAMPLE_W-1:0] sym;
  assign sym = {im_i, re_i};

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_word
    localparam int SRC = frame_src(g, CP_WORDS, SYM_WORDS);
    assign frame_o[g] = sym[SRC];
  end

endmodule

// File: rtl/cps_frame_store.sv
module cps_frame_store #(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_WORDS = 19
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  load_i,
  input  logic [FRAME_WORDS-1:0][SAMPLE_W-1:0]  frame_i,
  output logic [FRAME_WORDS-1:0][SAMPLE_W-1:0]  frame_o
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         frame_o <= '0;
    else if (load_i) frame_o <= frame_i;
  end

endmodule

// File: rtl/cps_word_counter.sv
module cps_word_counter #(
  parameter int FRAME_WORDS = 19,
  localparam int CW   = $clog2(FRAME_WORDS),
  localparam int LAST = FRAME_WORDS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  assign last_o = run_i && (cnt_o == CW'(LAST));

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          cnt_o <= '0;
    else if (start_i) cnt_o <= '0;
    else if (last_o)  cnt_o <= '0;
    else if (run_i)   cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cp_serializer.sv
module cp_serializer #(
  parameter int SAMPLE_W = 16,
  parameter int N_PTS    = 8,
  parameter int CP_WORDS = 3,
  localparam int SYM_WORDS   = 2 * N_PTS,
  localparam int FRAME_WORDS = CP_WORDS + SYM_WORDS,
  localparam int CW          = $clog2(FRAME_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_PTS*SAMPLE_W-1:0] in_re,
  input  logic [N_PTS*SAMPLE_W-1:0] in_im,
  output logic                      out_valid,
  output logic [SAMPLE_W-1:0]       out_data
);

  logic                                 busy;
  logic                                 accept_evt;
  logic                                 last_evt;
  logic [CW-1:0]                        word_cnt;
  logic [FRAME_WORDS-1:0][SAMPLE_W-1:0] frame_d;
  logic [FRAME_WORDS-1:0][SAMPLE_W-1:0] frame_q;

  assign accept_evt = in_valid && !busy;

  cps_frame_build #(
    .SAMPLE_W (SAMPLE_W),
    .N_PTS    (N_PTS),
    .CP_WORDS (CP_WORDS)
  ) u_build (
    .re_i    (in_re),
    .im_i    (in_im),
    .frame_o (frame_d)
  );

  cps_frame_store #(
    .SAMPLE_W    (SAMPLE_W),
    .FRAME_WORDS (FRAME_WORDS)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept_evt),
    .frame_i (frame_d),
    .frame_o (frame_q)
  );

  cps_word_counter #(
    .FRAME_WORDS (FRAME_WORDS)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept_evt),
    .run_i   (busy),
    .cnt_o   (word_cnt),
    .last_o  (last_evt)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             busy <= 1'b0;
    else if (accept_evt) busy <= 1'b1;
    else if (last_evt)   busy <= 1'b0;
  end

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_data  = busy ? frame_q[word_cnt] : '0;

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int SAMPLE_W = 16,
  parameter int N_PTS    = 8,
  parameter int CP_WORDS = 3,
  localparam int FRAME_WORDS = CP_WORDS + 2 * N_PTS,
  localparam int CW          = $clog2(FRAME_WORDS),
  localparam int LAST        = FRAME_WORDS - 1,
  localparam int P0_IM       = N_PTS - CP_WORDS
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [N_PTS*SAMPLE_W-1:0] in_im,
  input logic                      out_valid,
  input logic [SAMPLE_W-1:0]       out_data,
  input logic [CW-1:0]             cnt,
  input logic                      accept
);

  AST_START_NEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && cnt == '0)); // R2

  AST_PREFIX_HEAD: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_data == $past(in_im[P0_IM*SAMPLE_W +: SAMPLE_W]))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cnt != CW'(LAST)) |=> (out_valid && cnt == $past(cnt) + 1'b1)); // R5

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R6

  AST_WRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cnt == CW'(LAST)) |=> (!out_valid && in_ready && cnt == '0)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0)); // R8

endmodule

bind cp_serializer cps_checker #(
  .SAMPLE_W (SAMPLE_W),
  .N_PTS    (N_PTS),
  .CP_WORDS (CP_WORDS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_im     (in_im),
  .out_valid (out_valid),
  .out_data  (out_data),
  .cnt       (word_cnt),
  .accept    (accept_evt)
);

// File: tb/tb_cp_serializer.sv
module tb_cp_serializer;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int CP = 3;
  localparam int FW = CP + 2 * N;
  localparam int NV = 4;

  // {re_base, re_step, im_base, im_step}
  localparam logic [63:0] VEC [NV] = '{
    {16'h0100, 16'h0001, 16'h0200, 16'h0001},
    {16'hAAAA, 16'h0000, 16'h5555, 16'h0000},
    {16'h8000, 16'hF000, 16'h7FFF, 16'h1111},
    {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_re = '0;
  logic [N*W-1:0] in_im = '0;
  wire            in_ready;
  wire            out_valid;
  wire  [W-1:0]   out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cp_serializer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [N*W-1:0] ramp(input logic [W-1:0] base, input logic [W-1:0] step);
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = base + W'(k) * step;
    return v;
  endfunction

  // Expected word at frame position pos, written from R3/R4.
  function automatic logic [W-1:0] want(input logic [N*W-1:0] re, input logic [N*W-1:0] im, input int pos);
    if (pos < CP)          return im[(N - CP + pos) * W +: W];
    else if (pos < CP + N) return re[(pos - CP) * W +: W];
    else                   return im[(pos - CP - N) * W +: W];
  endfunction

  // Called at the negedge right after the accepting edge; ends at the idle negedge.
  task automatic expect_frame(input logic [N*W-1:0] re, input logic [N*W-1:0] im, input bit busy_offer);
    for (int j = 0; j < FW; j++) begin
      if (j > 0) @(negedge clk);
      chk(out_valid == 1'b1, "R5 valid run", {15'b0, out_valid}, 16'h1);
      chk(out_data == want(re, im, j), (j < CP) ? "R3 prefix word" : "R4 body word",
          out_data, want(re, im, j));
      if (busy_offer) chk(in_ready == 1'b0, "R6 ready low", {15'b0, in_ready}, 16'h0);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid drops", {15'b0, out_valid}, 16'h0);
    chk(in_ready == 1'b1, "R7 ready back", {15'b0, in_ready}, 16'h1);
    chk(out_data == '0, "R8 idle zero", out_data, 16'h0);
  endtask

  task automatic offer(input logic [N*W-1:0] re, input logic [N*W-1:0] im);
    chk(in_ready == 1'b1, "R2 ready before offer", {15'b0, in_ready}, 16'h1);
    in_re = re; in_im = im; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [N*W-1:0] re, im;
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", {15'b0, out_valid}, 16'h0);
    chk(in_ready == 1'b1, "R1 ready in reset", {15'b0, in_ready}, 16'h1);
    chk(out_data == '0, "R1 data in reset", out_data, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after release", {15'b0, out_valid}, 16'h0);

    // Table walk: R2, R3, R4, R5, R7, R8
    for (int v = 0; v < NV; v++) begin
      re = ramp(VEC[v][63:48], VEC[v][47:32]);
      im = ramp(VEC[v][31:16], VEC[v][15:0]);
      offer(re, im);
      in_valid = 1'b0;
      expect_frame(re, im, 1'b0);
      @(negedge clk);
    end

    // R6: offer held with other data during a frame is ignored, then taken (R7)
    re = ramp(16'h1234, 16'h0101);
    im = ramp(16'h4321, 16'h0202);
    offer(re, im);
    in_re = ~re; in_im = ~im;
    expect_frame(re, im, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_frame(~re, ~im, 1'b0);

    // R1: reset in mid-frame
    offer(re, im);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 mid-frame reset valid", {15'b0, out_valid}, 16'h0);
    chk(in_ready == 1'b1, "R1 mid-frame reset ready", {15'b0, in_ready}, 16'h1);
    chk(out_data == '0, "R1 mid-frame reset data", out_data, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: fresh frame after reset
    re = ramp(16'h0F0F, 16'h0003);
    im = ramp(16'hF0F0, 16'h0005);
    offer(re, im);
    in_valid = 1'b0;
    expect_frame(re, im, 1'b0);

    summary();
  end

endmodule